// File: doc/BRIEF.md
# Software Watchdog Downcounter

The block is a watchdog timer built around a six-bit down-counter held in one byte-wide register, together with an arming bit and a software-reset bit. Software reads and writes this register over a plain single-cycle register bus. Once the watchdog is armed, a prescaler divides the system clock, and the counter loses one step at the end of each prescaler period. Software has to rewrite the register before the count runs out. If it does not, the block drives a chip reset output for a fixed number of cycles and the register returns to its reset value.

A strap input stands for a board-level option that keeps the watchdog permanently enabled. While the strap is high, the watchdog runs from the moment reset is released, and software cannot stop it. Software can also request a reset at once by writing the software-reset bit low.

Top module: `wdog_downcount`

## Requirements
- R1: After `rst_ni` is released, `rd_data_o` reads 8'hFE (with the strap low) and `chip_rst_o` is low.
- R2: While bit 0 reads 0, the count in bits 7..2 does not change and `chip_rst_o` stays low, however many cycles pass.
- R3: Software can only set the arming bit (bit 0). A write with bit 0 low leaves it set. It is cleared only by a watchdog reset or by `rst_ni`.
- R4: When a refresh loads count N and the watchdog is active, the count drops by one every PRESCALE clocks. `chip_rst_o` rises after exactly max(N,1)*PRESCALE rising edges counted from the write edge, which means a loaded 0 behaves like a loaded 1.
- R5: A refresh is a write with bit 1 high. It loads bits 7..2 and restarts the prescaler. If the refresh lands in the same cycle as a prescaler step, the refresh wins and the loaded value is not decremented.
- R6: A write with bit 1 low raises `chip_rst_o` on the write edge itself, whether or not the watchdog is active.
- R7: `chip_rst_o` stays high for exactly PULSE_LEN cycles. From the edge where it rises, the register reads 8'hFE, with bit 0 equal to the strap.
- R8: While `hw_force_i` is high, bit 0 reads 1. After `rst_ni` is released, the count runs down from 63 and trips after 63*PRESCALE edges.
- R9: A write that arrives while `chip_rst_o` is high has no effect on the register.
- R10: The read value is made of the count in bits 7..2, a constant 1 in bit 1, and the active state (the armed bit OR the strap) in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hw_force_i | input | 1 | Strap that keeps the watchdog permanently active |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_data_i | input | 8 | Write data: count[7:2], software-reset bit [1], arm bit [0] |
| rd_data_o | output | 8 | Register read value |
| chip_rst_o | output | 1 | Reset request to the chip, held for PULSE_LEN cycles |

## Verification
The hardest situation to reach is a refresh that lands on the same edge as a prescaler step. The bench reaches it by counting cycles from a known refresh and issuing the second write exactly PRESCALE edges later. It then checks that the read value shows the reloaded count rather than the count minus one. Timeout lengths are swept over every six-bit count with a small prescaler, so both the zero and the one boundary are covered. Writes issued in the middle of a reset pulse are checked by reading the register back once the pulse ends.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int unsigned CNT_W = 6;
  localparam logic [7:0] WDOG_RESET_VAL = 8'hFE;

  typedef struct packed {
    logic [CNT_W-1:0] count;
    logic             sw_rst_n;
    logic             armed;
  } wdog_reg_t;
endpackage

// File: rtl/wdog_prescaler.sv
`timescale 1ns/1ps
module wdog_prescaler #(
  parameter int unsigned DIV = 3072
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic step_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] pre_q, pre_d;
  logic         wrap;

  always_comb begin
    wrap   = (pre_q == LAST);
    step_o = run_i && wrap;
    if (!run_i || restart_i || wrap) pre_d = '0;
    else                             pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end

  generate
    if (DIV > 1) begin : g_chk
      // R5: a restart always gives a full period before the next step
      p_restart_delay_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> !step_o);
      // R4: steps never come back to back
      p_step_spacing_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_o |=> !step_o);
    end
  endgenerate
endmodule

// File: rtl/wdog_pulse.sv
`timescale 1ns/1ps
module wdog_pulse #(
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic busy_o
);
  localparam int unsigned W = $clog2(PULSE_LEN + 1);

  logic [W-1:0] left_q, left_d;

  always_comb begin
    busy_o = (left_q != '0);
    if (busy_o)      left_d = left_q - 1'b1;
    else if (fire_i) left_d = W'(PULSE_LEN);
    else             left_d = left_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) left_q <= '0;
    else         left_q <= left_d;
  end

  // R6: a trip while idle starts the pulse on the next cycle
  p_fire_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && !busy_o |=> busy_o);

  generate
    if (PULSE_LEN > 1) begin : g_chk
      // R7: the pulse never lasts a single cycle
      p_pulse_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |=> busy_o);
    end
  endgenerate
endmodule

// File: rtl/wdog_ctrl_reg.sv
`timescale 1ns/1ps
module wdog_ctrl_reg
  import wdog_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      hw_force_i,
  input  logic      wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic      step_i,
  input  logic      busy_i,
  output wdog_reg_t reg_o,
  output logic      active_o,
  output logic      trip_o,
  output logic      restart_o
);
  wdog_reg_t reg_q, reg_d, wr_view;
  logic accept, refresh, sw_kill, expire;

  always_comb begin
    wr_view   = wdog_reg_t'(wr_data_i);
    accept    = wr_en_i && !busy_i;
    refresh   = accept && wr_view.sw_rst_n;
    sw_kill   = accept && !wr_view.sw_rst_n;
    expire    = step_i && !refresh && (reg_q.count <= CNT_W'(1));
    trip_o    = sw_kill || expire;
    restart_o = refresh || trip_o;
    active_o  = reg_q.armed || hw_force_i;

    reg_d = reg_q;
    if (trip_o) begin
      reg_d = wdog_reg_t'(WDOG_RESET_VAL);
    end else if (refresh) begin
      reg_d.count    = wr_view.count;
      reg_d.sw_rst_n = 1'b1;
      reg_d.armed    = reg_q.armed || wr_view.armed;
    end else if (step_i) begin
      reg_d.count = reg_q.count - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reg_q <= wdog_reg_t'(WDOG_RESET_VAL);
    else         reg_q <= reg_d;
  end

  assign reg_o = reg_q;

  // R3: the arming bit only drops on a trip
  p_armed_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_q.armed && !trip_o |=> reg_q.armed);
  // R2: an inactive watchdog without writes keeps its count
  p_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o && !wr_en_i |=> $stable(reg_q.count));
endmodule

// File: rtl/wdog_downcount.sv
`timescale 1ns/1ps
module wdog_downcount
  import wdog_pkg::*;
#(
  parameter int unsigned PRESCALE  = 3072,
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hw_force_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       chip_rst_o
);
  wdog_reg_t reg_cur;
  logic active, trip, restart, step, busy, run;

  assign run = active && !busy;

  wdog_prescaler #(.DIV(PRESCALE)) i_prescaler (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .restart_i (restart),
    .step_o    (step)
  );

  wdog_pulse #(.PULSE_LEN(PULSE_LEN)) i_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (trip),
    .busy_o (busy)
  );

  wdog_ctrl_reg i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hw_force_i (hw_force_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .step_i     (step),
    .busy_i     (busy),
    .reg_o      (reg_cur),
    .active_o   (active),
    .trip_o     (trip),
    .restart_o  (restart)
  );

  assign rd_data_o  = {reg_cur.count, reg_cur.sw_rst_n, active};
  assign chip_rst_o = busy;

  // R7: while the reset output is high the register shows its default
  p_rst_default_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_rst_o |-> rd_data_o[7:1] == WDOG_RESET_VAL[7:1]);
  // R9: writes during the pulse leave the register untouched
  p_ignore_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_rst_o && wr_en_i |=> rd_data_o[7:1] == WDOG_RESET_VAL[7:1]);
endmodule

// File: tb/test_wdog_downcount.sv
`timescale 1ns/1ps
module test_wdog_downcount;
  localparam int P = 4;
  localparam int R = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd;
  logic       crst;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  wdog_downcount #(.PRESCALE(P), .PULSE_LEN(R)) i_wdog_downcount (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .hw_force_i (hw),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .rd_data_o  (rd),
    .chip_rst_o (crst)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] v);
    wr_data = v;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // Expect the reset output to rise after m*P edges from the last reference edge
  task automatic expect_trip(int m, string req, logic b0);
    cyc(m * P - 1);
    chk(req, crst, 1'b0);
    cyc(1);
    chk(req, crst, 1'b1);
    chk({req, " R7"}, rd, {7'h7F, b0});
    cyc(R - 1);
    chk("R7", crst, 1'b1);
    cyc(1);
    chk("R7", crst, 1'b0);
    chk("R7", rd, {7'h7F, b0});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    chk("R1", rd, 8'hFE);
    chk("R1", crst, 1'b0);

    // R2 / R10: load a count while inactive, nothing moves
    wr(8'h06);
    chk("R10", rd, 8'h06);
    cyc(10 * P);
    chk("R2", crst, 1'b0);
    chk("R2", rd, 8'h06);

    // R4: sweep every count
    for (int n = 0; n < 64; n++) begin
      wr({n[5:0], 2'b11});
      chk("R10", rd, {n[5:0], 2'b11});
      expect_trip((n == 0) ? 1 : n, "R4", 1'b0);
      cyc(1);
    end

    // R3: arming is sticky, then cleared by a watchdog reset
    wr(8'hFF);
    wr(8'hFE);
    chk("R3", rd, 8'hFF);
    wr(8'hFC);
    chk("R6", crst, 1'b1);
    cyc(R);
    chk("R7", crst, 1'b0);
    chk("R3", rd, 8'hFE);

    // R5: refresh in mid-period restarts the interval
    wr(8'h0F);
    cyc(2 * P + 1);
    wr(8'h0F);
    expect_trip(3, "R5", 1'b0);
    cyc(1);
    // R5: refresh on the step edge wins
    wr(8'h0F);
    cyc(P - 1);
    wr(8'h0F);
    chk("R5", rd, 8'h0F);
    expect_trip(3, "R5", 1'b0);
    cyc(1);

    // R6: software reset while inactive
    wr(8'h3C);
    chk("R6", crst, 1'b1);
    cyc(R);
    chk("R6", crst, 1'b0);

    // R9: write during the pulse is dropped
    wr(8'h00);
    wr(8'h17);
    chk("R9", rd, 8'hFE);
    cyc(R - 1);
    chk("R9", crst, 1'b0);
    chk("R9", rd, 8'hFE);
    cyc(2 * P);
    chk("R9", crst, 1'b0);

    // R8: strap forces the watchdog on from reset
    hw = 1'b1;
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    chk("R8", rd, 8'hFF);
    expect_trip(63, "R8", 1'b1);
    wr(8'h0E);
    chk("R8", rd, 8'h0F);
    hw = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule